// File: doc/BRIEF.md
# Gated 16-bit Timer/Counter with Prescaler

This block is a 16-bit up-counter fed by an 8-bit prescaler. The prescaler advances either once per system clock (timer mode) or once per rising edge seen on an external clock pin (counter mode). An optional gate pin qualifies every prescaler step in both modes. A step happens only while that pin is high. Each prescaler wrap advances the 16-bit counter. Each counter wrap sets a sticky overflow flag, and that flag can drive an interrupt line when its enable bit is set. Three channel event strobes set sticky channel flags, and each flag raises its own interrupt line when enabled.

Software controls the block through a plain register write/read port. The port carries a 16-bit control word, the two reload values, a status word and live views of both counting stages. A 0-to-1 transition of the run bit preloads both stages from their reload registers, and counting starts on the following cycle. Clearing the run bit freezes both stages. The external clock and gate pins are asynchronous. Each passes through a synchronizer before use. The register port and the pins are control and status signals, so they carry no valid/ready handshake. A write takes effect on the clock edge where `reg_we` is high, and `reg_rdata` is a combinational view of the register addressed by `reg_addr`.

Top module: `tmr_gated`

## Requirements
- R1: After reset, every control bit, both reload registers, both counting stages and all flags read 0, and `irq_ovf` and `irq_ch` are low.
- R2: The control word at address 0 reads back as written. Bit layout: bit 0 run, bit 1 source select (0 = system clock, 1 = external pin), bit 2 gate enable, bit 3 overflow interrupt enable, bits 6:4 / 10:8 / 14:12 channel 0 / 1 / 2 mode (stored only), bits 7 / 11 / 15 channel 0 / 1 / 2 interrupt enable.
- R3: In timer mode the prescaler steps on every system clock while running. In counter mode it steps once for each rising edge of `ext_clk`, at most once per clock, and ignores the system clock otherwise.
- R4: With gate enable set, a step happens only if the synchronized `gate_in` is high. With gate enable clear, `gate_in` has no effect.
- R5: With run = 0, the prescaler and counter values are held.
- R6: A 0-to-1 transition of run loads the prescaler from address 1 and the counter from address 2, and stepping starts on the next cycle. Writing run = 1 again while running causes no reload.
- R7: The 8-bit prescaler counts up. On a step at 0xFF it reloads from address 1 and advances the counter by one.
- R8: On an advance at 0xFFFF the counter reloads from address 2 and sets the overflow flag (status bit 0). The flag stays set until software writes 1 to that bit.
- R9: `irq_ovf` is high exactly when the overflow flag and the overflow interrupt enable are both 1.
- R10: A one-cycle pulse on `ch_evt[n]` sets status bit n+1. The flag stays set until software writes 1 to that bit. `irq_ch[n]` is high only while that flag and channel n's enable bit are both 1.
- R11: Address map: 0 control, 1 prescaler reload (bits 7:0), 2 counter reload, 3 status (write 1 to clear), 4 live counter (read only), 5 live prescaler (read only). Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ext_clk | input | 1 | External count pin, asynchronous |
| gate_in | input | 1 | Gate pin, asynchronous |
| ch_evt | input | 3 | Channel event strobes |
| irq_ovf | output | 1 | Masked overflow interrupt |
| irq_ch | output | 3 | Masked channel interrupts |

## Verification
The bench builds the block with its defaults: an 8-bit prescaler, a 16-bit counter and two synchronizer stages. Reload values placed just below the wrap points make a prescaler period of only a few steps and a counter period of a handful of ticks. Prescaler wraps, counter wraps and the sticky overflow flag therefore all show up within a few hundred cycles of each run. With two synchronizer stages, a pin level driven before one edge gates the step two edges later. Because of that fixed latency, random gate patterns can be counted exactly against the bench model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int NCH    = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_PRE_RL = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT_RL = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CNT    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_PRE    = 3'd5;

  // control word, bit 15 first
  typedef struct packed {
    logic       ch2_en;
    logic [2:0] ch2_mode;
    logic       ch1_en;
    logic [2:0] ch1_mode;
    logic       ch0_en;
    logic [2:0] ch0_mode;
    logic       ovf_en;
    logic       gate_en;
    logic       ext_src;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/tmr_stage.sv
module tmr_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic [W-1:0] value,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;

  logic at_top;
  assign at_top = (value == TOP);
  assign wrap   = step & ~load & at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      value <= '0;
    else if (load)   value <= reload;
    else if (step)   value <= at_top ? reload : value + 1'b1;
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ovf_set,
  input  logic [NCH-1:0]    ch_evt,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [PRE_W-1:0]  pre_val,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl,
  output logic [PRE_W-1:0]  pre_rl,
  output logic [CNT_W-1:0]  cnt_rl,
  output logic              ovf_flag,
  output logic              irq_ovf,
  output logic [NCH-1:0]    irq_ch
);
  localparam int PRE_PAD = DATA_W - PRE_W;
  localparam int CNT_PAD = DATA_W - CNT_W;
  localparam int STAT_PAD = DATA_W - NCH - 1;

  logic wr_ctrl, wr_pre, wr_cnt, wr_stat;
  assign wr_ctrl = we && (addr == ADR_CTRL);
  assign wr_pre  = we && (addr == ADR_PRE_RL);
  assign wr_cnt  = we && (addr == ADR_CNT_RL);
  assign wr_stat = we && (addr == ADR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      pre_rl <= '0;
      cnt_rl <= '0;
    end else begin
      if (wr_ctrl) ctrl   <= ctrl_t'(wdata);
      if (wr_pre)  pre_rl <= wdata[PRE_W-1:0];
      if (wr_cnt)  cnt_rl <= wdata[CNT_W-1:0];
    end
  end

  // sticky overflow flag: a set in the same cycle wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ovf_flag <= 1'b0;
    else if (ovf_set)                ovf_flag <= 1'b1;
    else if (wr_stat && wdata[0])    ovf_flag <= 1'b0;
  end

  logic [NCH-1:0] ch_flag;
  logic [NCH-1:0] ch_en;
  assign ch_en = {ctrl.ch2_en, ctrl.ch1_en, ctrl.ch0_en};

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       ch_flag[n] <= 1'b0;
        else if (ch_evt[n])               ch_flag[n] <= 1'b1;
        else if (wr_stat && wdata[n+1])   ch_flag[n] <= 1'b0;
      end
      assign irq_ch[n] = ch_flag[n] & ch_en[n];
    end
  endgenerate

  assign irq_ovf = ovf_flag & ctrl.ovf_en;

  always_comb begin
    unique case (addr)
      ADR_CTRL:   rdata = DATA_W'(ctrl);
      ADR_PRE_RL: rdata = {{PRE_PAD{1'b0}}, pre_rl};
      ADR_CNT_RL: rdata = {{CNT_PAD{1'b0}}, cnt_rl};
      ADR_STAT:   rdata = {{STAT_PAD{1'b0}}, ch_flag, ovf_flag};
      ADR_CNT:    rdata = {{CNT_PAD{1'b0}}, cnt_val};
      ADR_PRE:    rdata = {{PRE_PAD{1'b0}}, pre_val};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_gated.sv
module tmr_gated
  import tmr_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_clk,
  input  logic              gate_in,
  input  logic [NCH-1:0]    ch_evt,
  output logic              irq_ovf,
  output logic [NCH-1:0]    irq_ch
);
  ctrl_t            ctrl_q;
  logic [PRE_W-1:0] pre_rl, pre_val;
  logic [CNT_W-1:0] cnt_rl, cnt_val;
  logic             ovf_flag;
  logic             pre_wrap, cnt_wrap;

  // pin synchronizers: bit 1 gate, bit 0 external clock
  logic [1:0] pins_s;
  tmr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({gate_in, ext_clk}), .q(pins_s)
  );

  logic ext_s, gate_s, ext_d, run_d;
  assign ext_s  = pins_s[0];
  assign gate_s = pins_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_d <= 1'b0;
      run_d <= 1'b0;
    end else begin
      ext_d <= ext_s;
      run_d <= ctrl_q.run;
    end
  end

  logic ext_rise, load, src_evt, step;
  assign ext_rise = ext_s & ~ext_d;
  assign load     = ctrl_q.run & ~run_d;
  assign src_evt  = ctrl_q.ext_src ? ext_rise : 1'b1;
  assign step     = ctrl_q.run & src_evt & (~ctrl_q.gate_en | gate_s);

  tmr_stage #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step),
    .reload(pre_rl), .value(pre_val), .wrap(pre_wrap)
  );

  tmr_stage #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .step(pre_wrap),
    .reload(cnt_rl), .value(cnt_val), .wrap(cnt_wrap)
  );

  tmr_regs #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ovf_set(cnt_wrap), .ch_evt(ch_evt),
    .cnt_val(cnt_val), .pre_val(pre_val),
    .rdata(reg_rdata), .ctrl(ctrl_q),
    .pre_rl(pre_rl), .cnt_rl(cnt_rl),
    .ovf_flag(ovf_flag), .irq_ovf(irq_ovf), .irq_ch(irq_ch)
  );
endmodule

// File: rtl/tmr_gated_chk.sv
module tmr_gated_chk #(
  parameter int PRE_W = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             load,
  input logic             ext_src,
  input logic             ext_rise,
  input logic             gate_en,
  input logic             gate_s,
  input logic             cnt_wrap,
  input logic             ovf_flag,
  input logic             ovf_clr,
  input logic             ovf_en,
  input logic             irq_ovf,
  input logic [PRE_W-1:0] pre_val,
  input logic [PRE_W-1:0] pre_rl,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cnt_rl
);
  // R5: stopped timer keeps both stages
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run) |=> ($stable(cnt_val) && $stable(pre_val)));

  // R6: start preloads both stages
  a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_val == $past(cnt_rl) && pre_val == $past(pre_rl)));

  // R3: in counter mode no step without an external edge
  a_r3_ext_only: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_src && !ext_rise && !load) |=> $stable(pre_val));

  // R4: closed gate blocks the prescaler
  a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !gate_s && !load) |=> $stable(pre_val));

  // R8: wrap sets the flag, and it stays until cleared
  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |=> ovf_flag);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R9: masked interrupt
  a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_en) |-> !irq_ovf);
endmodule

bind tmr_gated tmr_gated_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .run(ctrl_q.run), .load(load), .ext_src(ctrl_q.ext_src), .ext_rise(ext_rise),
  .gate_en(ctrl_q.gate_en), .gate_s(gate_s),
  .cnt_wrap(cnt_wrap), .ovf_flag(ovf_flag),
  .ovf_clr(reg_we && reg_addr == 3'd3 && reg_wdata[0]),
  .ovf_en(ctrl_q.ovf_en), .irq_ovf(irq_ovf),
  .pre_val(pre_val), .pre_rl(pre_rl), .cnt_val(cnt_val), .cnt_rl(cnt_rl)
);

// File: tb/sim_tmr_gated.sv
`timescale 1ns/1ps
module sim_tmr_gated;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ext_clk = 1'b0;
  logic        gate_in = 1'b0;
  logic [2:0]  ch_evt = '0;
  logic        irq_ovf;
  logic [2:0]  irq_ch;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tmr_gated u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
    .gate_in(gate_in), .ch_evt(ch_evt), .irq_ovf(irq_ovf), .irq_ch(irq_ch)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 16'(d);
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 3'(a);
    #1 d = int'(reg_rdata);
  endtask

  // expected stage values after n prescaler steps from a fresh load
  function automatic void model(input int prl, input int crl, input int n,
                                output int pv, output int cv, output int ov);
    int pper, cper, ticks;
    pper  = 256 - prl;
    cper  = 65536 - crl;
    ticks = n / pper;
    pv = prl + (n % pper);
    cv = crl + (ticks % cper);
    ov = (ticks >= cper) ? 1 : 0;
  endfunction

  task automatic verify(input string req, input int prl, input int crl, input int n);
    int pv, cv, ov, d;
    model(prl, crl, n, pv, cv, ov);
    rd(4, d); check({req, " counter"}, d, cv);
    rd(5, d); check({req, " prescaler"}, d, pv);
    rd(3, d); check({req, " overflow flag"}, d & 1, ov);
  endtask

  task automatic start(input int prl, input int crl, input int ctl);
    wr(1, prl); wr(2, crl); wr(0, ctl | 1);
  endtask

  task automatic pulses(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (2) @(negedge clk);
      ext_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_up();
  end

  initial begin
    int d, ones, m, prl, crl, ctl, pv, cv, ov;
    void'($urandom(32'h1F2E3D4C));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a, d); check("R1 reset register", d, 0);
    end
    check("R1 irq_ovf", int'(irq_ovf), 0);
    check("R1 irq_ch", int'(irq_ch), 0);

    // R2 / R11 layout and address map
    wr(0, 16'hFEF0); rd(0, d); check("R2 control readback", d, 16'hFEF0);
    wr(1, 16'hABCD); rd(1, d); check("R11 prescaler reload width", d, 16'h00CD);
    rd(6, d); check("R11 unmapped address", d, 0);

    // R10 channel flags and enables (bits 7/11/15)
    @(negedge clk); ch_evt = 3'b010;
    @(negedge clk); ch_evt = 3'b000;
    rd(3, d); check("R10 channel 1 flag", d, 16'h0004);
    check("R10 irq_ch enabled", int'(irq_ch), 3'b010);
    wr(0, 16'hF6F0);
    check("R10 irq_ch masked", int'(irq_ch), 0);
    rd(3, d); check("R10 flag kept while masked", d, 16'h0004);
    wr(3, 16'h0004); rd(3, d); check("R10 flag cleared", d, 0);
    wr(0, 0);

    // R7 R8 R9 directed wrap chain: prescaler period 2, counter period 1
    start(8'hFE, 16'hFFFF, 0);
    repeat (5) @(posedge clk);
    wr(0, 0);
    verify("R7 R8 wrap chain", 8'hFE, 16'hFFFF, 5);
    check("R9 irq_ovf masked", int'(irq_ovf), 0);
    wr(0, 16'h0008);
    check("R9 irq_ovf enabled", int'(irq_ovf), 1);
    wr(3, 1); rd(3, d);
    check("R8 write-1 clear", d & 1, 0);
    check("R9 irq_ovf after clear", int'(irq_ovf), 0);

    // R5 hold while stopped
    start(8'hF0, 16'h1234, 0);
    repeat (37) @(posedge clk);
    wr(0, 0);
    verify("R5 stopped", 8'hF0, 16'h1234, 37);
    repeat (20) @(negedge clk);
    verify("R5 still held", 8'hF0, 16'h1234, 37);

    // R6 rewriting run does not reload
    start(8'hF8, 16'h0100, 0);
    repeat (15) @(posedge clk);
    wr(0, 1);
    repeat (20) @(posedge clk);
    wr(0, 0);
    verify("R6 no reload on rewrite", 8'hF8, 16'h0100, 36);
    start(8'hF8, 16'h0100, 0);
    wr(0, 0);
    verify("R6 reload on restart", 8'hF8, 16'h0100, 1);

    // R3 counter mode: system clock ignored, pin edges counted
    start(8'hF0, 16'h0000, 16'h0002);
    repeat (25) @(negedge clk);
    verify("R3 no ext edges", 8'hF0, 16'h0000, 0);
    pulses(7);
    repeat (6) @(negedge clk);
    wr(0, 16'h0002);
    verify("R3 ext edges", 8'hF0, 16'h0000, 7);

    // R4 gate in counter mode
    gate_in = 1'b0;
    start(8'hF0, 16'h0000, 16'h0006);
    repeat (3) @(negedge clk);
    pulses(5);
    repeat (6) @(negedge clk);
    wr(0, 16'h0006);
    verify("R4 gate closed counter", 8'hF0, 16'h0000, 0);
    gate_in = 1'b1;
    start(8'hF0, 16'h0000, 16'h0006);
    repeat (3) @(negedge clk);
    pulses(4);
    repeat (6) @(negedge clk);
    wr(0, 16'h0006);
    verify("R4 gate open counter", 8'hF0, 16'h0000, 4);

    // R4 pin ignored when gate disabled
    gate_in = 1'b0;
    start(8'hF0, 16'h0000, 0);
    repeat (30) @(posedge clk);
    wr(0, 0);
    verify("R4 gate disabled", 8'hF0, 16'h0000, 30);

    // R4 random gate pattern in timer mode
    start(8'hF4, 16'hFFFD, 16'h0004);
    repeat (3) @(negedge clk);
    ones = 0;
    for (int i = 0; i < 80; i++) begin
      gate_in = 1'($urandom_range(0, 1));
      if (gate_in) ones++;
      @(negedge clk);
    end
    gate_in = 1'b0;
    repeat (4) @(negedge clk);
    wr(0, 16'h0004);
    verify("R4 random gate", 8'hF4, 16'hFFFD, ones);
    wr(3, 1);

    // R3 R7 R8 R9 random timer runs
    for (int t = 0; t < 10; t++) begin
      prl = $urandom_range(200, 255);
      crl = $urandom_range(16'hFFF0, 16'hFFFF);
      m   = $urandom_range(1, 400);
      ctl = ($urandom_range(0, 1) != 0) ? 16'h0008 : 0;
      start(prl, crl, ctl);
      repeat (m) @(posedge clk);
      wr(0, ctl);
      verify("R3 R7 R8 random run", prl, crl, m);
      model(prl, crl, m, pv, cv, ov);
      check("R9 random irq_ovf", int'(irq_ovf), (ov != 0 && ctl != 0) ? 1 : 0);
      wr(3, 1);
    end

    finish_up();
  end
endmodule